// File: doc/BRIEF.md
# Configurable Register-Mapped GPIO Controller

This block connects a group of general-purpose pins to a simple register bus. The bus has a word address, a write enable, write data and combinational read data. Software reads the pin levels through a line-state register. It drives lines high or low through set and clear registers, and it makes each line an input or an output through a direction register. That direction register can be written through two views of opposite polarity.

Elaboration parameters set several things. Each of the set, clear, output-polarity direction and input-polarity direction registers can be present or absent, and the behaviour falls back in a defined way when one is absent. Other parameters give the register width, the number of lines actually wired, the bus byte order, and whether the controller may drive its pins at all.

Word addresses: 0 line state, 1 set, 2 clear, 3 direction (1 = output), 4 direction (1 = input). Addresses 5 to 7 are unmapped.

Top module: `gpio_mmio_ctrl`

## Requirements
- R1: While a direction view exists, reset leaves every line an input (pin_oe all 0, address 4 reads the line mask) and every output value bit 0.
- R2: With both set and clear present, writing address 1 raises the output bits written as 1 and leaves bits written as 0 unchanged. Reading address 1 returns the output latch.
- R3: Writing address 2 lowers the output bits written as 1 and leaves bits written as 0 unchanged. Reading address 2 returns the output latch.
- R4: With set present and clear absent, writing address 1 loads the whole output latch, so a 0 bit drives its line low.
- R5: With set absent, writing address 0 loads the whole output latch. With set present, a write to address 0 has no effect.
- R6: Writing address 3 makes each line written 1 an output and each line written 0 an input. Reading address 3 returns the direction, with 1 meaning output.
- R7: Writing address 4 makes each line written 1 an input and each line written 0 an output. Reading address 4 returns the inverted direction over the usable lines.
- R8: Address 0 reads the level on pin_in, with bit n for line n, as it stood two clock edges before the read.
- R9: Bits at or above LINE_CNT read as 0, ignore writes, and never drive pin_out or pin_oe.
- R10: With BUS_BIG_END set, the bytes of the write data are reversed before use and the bytes of the read data are reversed before return. With it clear, both pass unchanged.
- R11: With DRIVE_OFF set, pin_oe and pin_out stay 0 whatever is written. Direction writes still update the read-back.
- R12: A register write shows on pin_out and pin_oe after the next clock edge. pin_oe equals the direction over usable lines. With no direction view present, every usable line is a permanent output.
- R13: An absent register or an unmapped address reads as 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| pin_in | input | DATA_W | Pin levels seen from outside |
| pin_out | output | DATA_W | Output value per line |
| pin_oe | output | DATA_W | Output enable per line |

## Verification
The bench builds four copies that share the bus, each with DATA_W 16 and LINE_CNT 12, so the four unwired bits test masking on every access.

- One copy has every register present and uses little-endian order.
- One drops the clear register and uses big-endian order, which covers the full-load fallback and the byte reversal together.
- One has no set register and no direction view, which covers loading through address 0 and permanently enabled outputs.
- One forbids output.

An arithmetic sweep of 80 patterns writes all five registers and reads back all eight addresses of every copy after each write, which makes the sweep close to exhaustive.

// File: rtl/gpio_mmio_pkg.sv
package gpio_mmio_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_LEVEL = 3'd0,
    REG_SET   = 3'd1,
    REG_CLR   = 3'd2,
    REG_DOUT  = 3'd3,
    REG_DIN   = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_out = stage2_q;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  // R8
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_byte_order.sv
module gpio_byte_order #(
  parameter int W    = 32,
  parameter bit SWAP = 1'b0
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int NB = W / 8;

  generate
    if (SWAP) begin : g_swap
      for (genvar b = 0; b < NB; b++) begin : g_byte
        assign dout[8*b +: 8] = din[8*(NB-1-b) +: 8];
      end
    end else begin : g_pass
      assign dout = din;
    end
  endgenerate
endmodule

// File: rtl/gpio_line_regs.sv
module gpio_line_regs
  import gpio_mmio_pkg::*;
#(
  parameter int W         = 32,
  parameter int LINES     = 32,
  parameter bit HAS_SET   = 1'b1,
  parameter bit HAS_CLR   = 1'b1,
  parameter bit HAS_DOUT  = 1'b1,
  parameter bit HAS_DIN   = 1'b1,
  parameter bit DRIVE_OFF = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wval,
  output logic [W-1:0]      out_q,
  output logic [W-1:0]      dir_q
);
  localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] MASK    = (LINES >= W) ? {W{1'b1}} : ((ONE << LINES) - ONE);
  localparam bit           HAS_DIR = HAS_DOUT | HAS_DIN;
  localparam logic [W-1:0] DIR_RST = HAS_DIR ? '0 : MASK;

  logic [W-1:0] wm;
  logic [W-1:0] out_d, dir_d;
  logic         out_en, dir_en;

  assign wm = wval & MASK;

  always_comb begin
    out_d  = out_q;
    dir_d  = dir_q;
    out_en = 1'b0;
    dir_en = 1'b0;
    if (we) begin
      case (reg_sel_e'(addr))
        REG_LEVEL: if (!HAS_SET && !DRIVE_OFF) begin
          out_d  = wm;
          out_en = 1'b1;
        end
        REG_SET: if (HAS_SET && !DRIVE_OFF) begin
          out_d  = HAS_CLR ? (out_q | wm) : wm;
          out_en = 1'b1;
        end
        REG_CLR: if (HAS_CLR && !DRIVE_OFF) begin
          out_d  = out_q & ~wm;
          out_en = 1'b1;
        end
        REG_DOUT: if (HAS_DOUT) begin
          dir_d  = wm;
          dir_en = 1'b1;
        end
        REG_DIN: if (HAS_DIN) begin
          dir_d  = ~wval & MASK;
          dir_en = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (out_en) out_q <= out_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= DIR_RST;
    else if (dir_en) dir_q <= dir_d;
  end

  // R2
  set_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_SET && HAS_CLR && !DRIVE_OFF && we && addr == REG_SET)
      |=> ((out_q & $past(wm)) == $past(wm)));

  // R3
  clr_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_CLR && !DRIVE_OFF && we && addr == REG_CLR)
      |=> ((out_q & $past(wm)) == '0));

  // R7
  in_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_DIN && we && addr == REG_DIN) |=> (dir_q == (~$past(wval) & MASK)));

  // R9
  unused_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_q | dir_q) & ~MASK) == '0);

  // R11
  no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    DRIVE_OFF |-> (out_q == '0));
endmodule

// File: rtl/gpio_mmio_ctrl.sv
module gpio_mmio_ctrl
  import gpio_mmio_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int LINE_CNT    = 32,
  parameter bit HAS_SET_REG = 1'b1,
  parameter bit HAS_CLR_REG = 1'b1,
  parameter bit HAS_DOUT    = 1'b1,
  parameter bit HAS_DIN     = 1'b1,
  parameter bit DRIVE_OFF   = 1'b0,
  parameter bit BUS_BIG_END = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_oe
);
  localparam logic [DATA_W-1:0] ONE  = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] MASK = (LINE_CNT >= DATA_W) ? {DATA_W{1'b1}}
                                       : ((ONE << LINE_CNT) - ONE);

  logic              rst_n_s;
  logic [DATA_W-1:0] wval, rd_raw, out_q, dir_q, lvl_q;

  gpio_rst_sync u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_s)
  );

  gpio_byte_order #(.W(DATA_W), .SWAP(BUS_BIG_END)) u_wr_order (
    .din (bus_wdata),
    .dout(wval)
  );

  gpio_line_regs #(
    .W(DATA_W), .LINES(LINE_CNT), .HAS_SET(HAS_SET_REG), .HAS_CLR(HAS_CLR_REG),
    .HAS_DOUT(HAS_DOUT), .HAS_DIN(HAS_DIN), .DRIVE_OFF(DRIVE_OFF)
  ) u_regs (
    .clk  (clk),
    .rst_n(rst_n_s),
    .we   (bus_we),
    .addr (bus_addr),
    .wval (wval),
    .out_q(out_q),
    .dir_q(dir_q)
  );

  gpio_in_sync #(.W(DATA_W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n_s),
    .d    (pin_in),
    .q    (lvl_q)
  );

  always_comb begin
    rd_raw = '0;
    case (reg_sel_e'(bus_addr))
      REG_LEVEL: rd_raw = lvl_q & MASK;
      REG_SET:   if (HAS_SET_REG) rd_raw = out_q;
      REG_CLR:   if (HAS_CLR_REG) rd_raw = out_q;
      REG_DOUT:  if (HAS_DOUT)    rd_raw = dir_q;
      REG_DIN:   if (HAS_DIN)     rd_raw = ~dir_q & MASK;
      default:   rd_raw = '0;
    endcase
  end

  gpio_byte_order #(.W(DATA_W), .SWAP(BUS_BIG_END)) u_rd_order (
    .din (rd_raw),
    .dout(bus_rdata)
  );

  assign pin_out = DRIVE_OFF ? '0 : out_q;
  assign pin_oe  = DRIVE_OFF ? '0 : dir_q;

  // R12
  oe_follows_dir_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!DRIVE_OFF && bus_we && HAS_DOUT && bus_addr == REG_DOUT)
      |=> (pin_oe == ($past(wval) & MASK)));
endmodule

// File: tb/gpio_mmio_ctrl_test.sv
module gpio_mmio_ctrl_test;
  localparam logic [15:0] MASK = 16'h0FFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic        we = 1'b0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] ext = 16'h0;
  logic [15:0] p_rd [4];
  logic [15:0] p_out[4];
  logic [15:0] p_oe [4];

  // per-copy configuration: set, clear, dir-out view, dir-in view, drive off, big endian
  localparam bit C_SET [4] = '{1'b1, 1'b1, 1'b0, 1'b1};
  localparam bit C_CLR [4] = '{1'b1, 1'b0, 1'b1, 1'b1};
  localparam bit C_DOUT[4] = '{1'b1, 1'b1, 1'b0, 1'b1};
  localparam bit C_DIN [4] = '{1'b1, 1'b1, 1'b0, 1'b1};
  localparam bit C_OFF [4] = '{1'b0, 1'b0, 1'b0, 1'b1};
  localparam bit C_BE  [4] = '{1'b0, 1'b1, 1'b0, 1'b0};

  logic [15:0] m_out[4];
  logic [15:0] m_dir[4];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_mmio_ctrl #(.DATA_W(16), .LINE_CNT(12), .HAS_SET_REG(1'b1), .HAS_CLR_REG(1'b1),
    .HAS_DOUT(1'b1), .HAS_DIN(1'b1), .DRIVE_OFF(1'b0), .BUS_BIG_END(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(p_rd[0]), .pin_in(ext), .pin_out(p_out[0]), .pin_oe(p_oe[0]));

  gpio_mmio_ctrl #(.DATA_W(16), .LINE_CNT(12), .HAS_SET_REG(1'b1), .HAS_CLR_REG(1'b0),
    .HAS_DOUT(1'b1), .HAS_DIN(1'b1), .DRIVE_OFF(1'b0), .BUS_BIG_END(1'b1)) uut_be (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(p_rd[1]), .pin_in(ext), .pin_out(p_out[1]), .pin_oe(p_oe[1]));

  gpio_mmio_ctrl #(.DATA_W(16), .LINE_CNT(12), .HAS_SET_REG(1'b0), .HAS_CLR_REG(1'b1),
    .HAS_DOUT(1'b0), .HAS_DIN(1'b0), .DRIVE_OFF(1'b0), .BUS_BIG_END(1'b0)) uut_ns (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(p_rd[2]), .pin_in(ext), .pin_out(p_out[2]), .pin_oe(p_oe[2]));

  gpio_mmio_ctrl #(.DATA_W(16), .LINE_CNT(12), .HAS_SET_REG(1'b1), .HAS_CLR_REG(1'b1),
    .HAS_DOUT(1'b1), .HAS_DIN(1'b1), .DRIVE_OFF(1'b1), .BUS_BIG_END(1'b0)) uut_no (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(p_rd[3]), .pin_in(ext), .pin_out(p_out[3]), .pin_oe(p_oe[3]));

  function automatic logic [15:0] swp(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < 4; i++) begin
      m_out[i] = 16'h0;
      m_dir[i] = (C_DOUT[i] || C_DIN[i]) ? 16'h0 : MASK;
    end
  endfunction

  function automatic void model_wr(input logic [2:0] a, input logic [15:0] d);
    for (int i = 0; i < 4; i++) begin
      logic [15:0] v, wm;
      v  = C_BE[i] ? swp(d) : d;
      wm = v & MASK;
      case (a)
        3'd0: if (!C_SET[i] && !C_OFF[i]) m_out[i] = wm;
        3'd1: if (C_SET[i] && !C_OFF[i]) m_out[i] = C_CLR[i] ? (m_out[i] | wm) : wm;
        3'd2: if (C_CLR[i] && !C_OFF[i]) m_out[i] = m_out[i] & ~wm;
        3'd3: if (C_DOUT[i]) m_dir[i] = wm;
        3'd4: if (C_DIN[i])  m_dir[i] = ~v & MASK;
        default: ;
      endcase
    end
  endfunction

  function automatic logic [15:0] model_rd(input int i, input logic [2:0] a);
    logic [15:0] v;
    case (a)
      3'd0: v = ext & MASK;
      3'd1: v = C_SET[i]  ? m_out[i] : 16'h0;
      3'd2: v = C_CLR[i]  ? m_out[i] : 16'h0;
      3'd3: v = C_DOUT[i] ? m_dir[i] : 16'h0;
      3'd4: v = C_DIN[i]  ? (~m_dir[i] & MASK) : 16'h0;
      default: v = 16'h0;
    endcase
    return C_BE[i] ? swp(v) : v;
  endfunction

  task automatic chk(input string req, input int i, input string what,
                     input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s copy%0d %s actual %h expected %h", req, i, what, got, exp);
    end
  endtask

  // called just after a falling edge; reads are combinational
  task automatic check_all(input string tag);
    for (int i = 0; i < 4; i++) begin
      chk({tag, " R9 R11 R12"}, i, "pin_out", p_out[i], C_OFF[i] ? 16'h0 : m_out[i]);
      chk({tag, " R9 R11 R12"}, i, "pin_oe",  p_oe[i],  C_OFF[i] ? 16'h0 : m_dir[i]);
    end
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a);
      #1;
      for (int i = 0; i < 4; i++) begin
        string rt;
        rt = (a == 0) ? "R8 R10" : (a > 4) ? "R13" : {tag, " R10 R13"};
        chk(rt, i, $sformatf("read addr %0d", a), p_rd[i], model_rd(i, 3'(a)));
      end
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input string tag);
    @(negedge clk);
    addr  = a;
    wdata = d;
    we    = 1'b1;
    @(negedge clk);
    we = 1'b0;
    model_wr(a, d);
    check_all(tag);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: state after reset
    check_all("R1");

    // writes above the line limit only: R9
    wr(3'd3, 16'hF000, "R6 R9");
    wr(3'd1, 16'hF000, "R2 R4 R9");

    for (int k = 0; k < 80; k++) begin
      logic [15:0] d;
      d = 16'(k * 16'h9E37) ^ 16'(k << 3);
      @(negedge clk);
      ext = d ^ 16'h5A5A;
      repeat (3) @(negedge clk);
      wr(3'd3, d,        "R6");
      wr(3'd1, d,        "R2 R4 R13");
      wr(3'd2, d >> 1,   "R3");
      wr(3'd1, ~d,       "R2 R4");
      wr(3'd4, ~d ^ 16'h00F0, "R7");
      wr(3'd0, d ^ 16'h0F0F, "R5");
      wr(3'd2, 16'h00FF, "R3 R5");
      wr(3'(5 + (k % 3)), d, "R13");
    end

    // R8: two-edge latency on the level register
    @(negedge clk);
    ext = 16'h0ABC;
    @(negedge clk);
    addr = 3'd0;
    #1;
    chk("R8", 0, "level after one edge", p_rd[0], 16'h0ABC ^ 16'h0ABC ^ (16'(79 * 16'h9E37) ^ 16'(79 << 3) ^ 16'h5A5A) & MASK);
    @(negedge clk);
    #1;
    chk("R8", 0, "level after two edges", p_rd[0], 16'h0ABC);
    chk("R8 R10", 1, "level after two edges", p_rd[1], swp(16'h0ABC));

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule